// File: doc/BRIEF.md
# AXI Address-Channel Protection Gate

This block sits on the read-address and write-address channels of an AXI link. It sits between a master and the memory side. Every address handshake is checked against a small set of protection regions before it is passed on. A region is defined by an enable bit, an inclusive lower and upper bound, and a three-bit access code. The check covers the whole byte footprint of the burst. The lowest and highest byte addresses are both looked up. When several regions cover an address, the region with the lowest index wins. If the two ends of the footprint land in regions with different rights, the tighter of the two applies. A permitted request passes through in the same cycle, with its payload unchanged.

A request that fails is never accepted. Its valid is withheld from memory and its ready is withheld from the master. One clock edge later a sticky interrupt flag rises. The offending address and control fields are latched into a per-channel error-address and error-control register. A write-side and a read-side violation in the same cycle load both register pairs. While the flag is up, both channels are frozen and the master side is no longer monitored. Software releases the gate by pulsing a clear input.

Top module: `axi_addr_guard`

## Requirements
- R1: When the write request is permitted (rights are read-write), `sAwvalid` equals `mAwvalid` and `mAwready` equals `sAwready` in the same cycle. All AW payload fields appear unchanged on the memory side.
- R2: When the read request is permitted (rights are read-only or read-write), `sArvalid` equals `mArvalid` and `mArready` equals `sArready` in the same cycle. All AR payload fields appear unchanged on the memory side.
- R3: An address matches region i when `regionEn[i]` is 1 and `lo_i <= addr <= hi_i`. Bounds are taken from slice i of `regionLo`/`regionHi`. Among matching regions the lowest index decides. An address that matches no enabled region has no access.
- R4: For a privileged request (`prot[0]`=1), the access codes give these rights: 000 and 100 give none; 101 and 110 give read-only; all other codes give read-write.
- R5: For an unprivileged request (`prot[0]`=0), the access codes give these rights: 010 and 110 give read-only; 011 and 111 give read-write; all other codes give none.
- R6: The footprint of a burst depends on its burst type. For FIXED (00) it is addr to addr+2^size-1. For INCR (01) it is addr to addr+(len+1)*2^size-1. For WRAP (10) it is the (len+1)*2^size-byte block aligned around addr. The tighter of the rights at the two ends applies. Burst type 11, and any footprint that runs past the top of the address space, is denied.
- R7: A denied request with the flag clear keeps the memory-side valid and the master-side ready low. `irqFlag` is 1 after the next clock edge.
- R8: A write-side violation loads `werrAddr` with the address and `werrCtrl` with {id, len, size, burst, prot} (MSB first) at the next clock edge.
- R9: A read-side violation loads `rerrAddr`/`rerrCtrl` in the same way. When both channels violate in one cycle, both pairs are loaded.
- R10: While `irqFlag` is 1, all four valid/ready outputs stay low, the flag stays set, and no error register changes, whatever the master drives.
- R11: A one-cycle `errClear` pulse drops the flag at the next edge, and forwarding resumes in the cycle after that. A violation in the same cycle as a clear leaves the flag set.
- R12: After reset, `irqFlag` and all four error registers are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regionEn | input | NREG | Per-region enable |
| regionLo | input | NREG*ADDR_W | Inclusive lower bounds, region i in slice i |
| regionHi | input | NREG*ADDR_W | Inclusive upper bounds |
| regionAp | input | NREG*3 | Access codes, three bits per region |
| mAwvalid | input | 1 | Master write-address valid |
| mAwready | output | 1 | Write-address ready toward master |
| mAwaddr | input | ADDR_W | Write address |
| mAwid | input | ID_W | Write ID |
| mAwlen | input | 8 | Write burst length minus one |
| mAwsize | input | 3 | Write beat size code |
| mAwburst | input | 2 | Write burst type |
| mAwprot | input | 3 | Write protection bits |
| sAwvalid | output | 1 | Write-address valid toward memory |
| sAwready | input | 1 | Memory write-address ready |
| sAwaddr | output | ADDR_W | Forwarded write address |
| sAwid | output | ID_W | Forwarded write ID |
| sAwlen | output | 8 | Forwarded write length |
| sAwsize | output | 3 | Forwarded write size |
| sAwburst | output | 2 | Forwarded write burst type |
| sAwprot | output | 3 | Forwarded write protection |
| mArvalid | input | 1 | Master read-address valid |
| mArready | output | 1 | Read-address ready toward master |
| mAraddr | input | ADDR_W | Read address |
| mArid | input | ID_W | Read ID |
| mArlen | input | 8 | Read burst length minus one |
| mArsize | input | 3 | Read beat size code |
| mArburst | input | 2 | Read burst type |
| mArprot | input | 3 | Read protection bits |
| sArvalid | output | 1 | Read-address valid toward memory |
| sArready | input | 1 | Memory read-address ready |
| sAraddr | output | ADDR_W | Forwarded read address |
| sArid | output | ID_W | Forwarded read ID |
| sArlen | output | 8 | Forwarded read length |
| sArsize | output | 3 | Forwarded read size |
| sArburst | output | 2 | Forwarded read burst type |
| sArprot | output | 3 | Forwarded read protection |
| errClear | input | 1 | Write-one-to-clear pulse for the flag |
| irqFlag | output | 1 | Sticky non-maskable violation flag |
| werrAddr | output | ADDR_W | Captured write-violation address |
| werrCtrl | output | ID_W+16 | Captured write-violation control fields |
| rerrAddr | output | ADDR_W | Captured read-violation address |
| rerrCtrl | output | ID_W+16 | Captured read-violation control fields |

## Verification
The forwarding decision is combinational, so the valid/ready outputs and the payload are due in the cycle the request is driven. Inputs change on the falling edge and these outputs are sampled two nanoseconds later, before the next rising edge. The flag and the error registers change on the rising edge after the violating cycle. A clear likewise takes effect on the rising edge after the pulse. These are read on the following falling edge, one register stage after the stimulus. The blocked-state checks hold the inputs across several edges and re-sample each time.

// File: rtl/axgate_pkg.sv
package axgate_pkg;

  typedef enum logic [1:0] {
    ACC_NONE = 2'd0,
    ACC_RO   = 2'd1,
    ACC_RW   = 2'd2
  } access_e;

  typedef struct packed {
    logic loadW;
    logic loadR;
    logic setFlag;
  } strobe_t;

  localparam logic [1:0] BURST_FIXED = 2'b00;
  localparam logic [1:0] BURST_INCR  = 2'b01;
  localparam logic [1:0] BURST_WRAP  = 2'b10;

  function automatic access_e decodeAp(input logic [2:0] ap, input logic priv);
    access_e r;
    if (priv) begin
      case (ap)
        3'b000, 3'b100: r = ACC_NONE;
        3'b101, 3'b110: r = ACC_RO;
        default:        r = ACC_RW;
      endcase
    end else begin
      case (ap)
        3'b010, 3'b110: r = ACC_RO;
        3'b011, 3'b111: r = ACC_RW;
        default:        r = ACC_NONE;
      endcase
    end
    return r;
  endfunction

  function automatic access_e tighter(input access_e a, input access_e b);
    return (a < b) ? a : b;
  endfunction

endpackage

// File: rtl/axgate_perm.sv
module axgate_perm
  import axgate_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int NREG   = 4
) (
  input  logic [ADDR_W-1:0]      addr,
  input  logic [7:0]             len,
  input  logic [2:0]             size,
  input  logic [1:0]             burst,
  input  logic                   priv,
  input  logic [NREG-1:0]        regionEn,
  input  logic [NREG*ADDR_W-1:0] regionLo,
  input  logic [NREG*ADDR_W-1:0] regionHi,
  input  logic [NREG*3-1:0]      regionAp,
  output access_e                grant
);
  localparam int SPAN_W = 16;
  localparam int EXT_W  = ADDR_W + 1;

  logic [SPAN_W-1:0] beatCount, spanBytes, beatBytes;
  logic [EXT_W-1:0]  addrExt, spanExt, beatExt, lowAddr, highAddr;
  logic              badBurst, overflow;
  logic [NREG-1:0]   hitLo, hitHi;
  access_e           lowAcc, highAcc;

  assign beatCount = SPAN_W'(len) + SPAN_W'(1);
  assign spanBytes = beatCount << size;
  assign beatBytes = SPAN_W'(1) << size;
  assign addrExt   = EXT_W'(addr);
  assign spanExt   = EXT_W'(spanBytes);
  assign beatExt   = EXT_W'(beatBytes);

  // Byte footprint of the burst
  always_comb begin
    badBurst = 1'b0;
    lowAddr  = addrExt;
    highAddr = addrExt;
    case (burst)
      BURST_FIXED: highAddr = addrExt + beatExt - EXT_W'(1);
      BURST_INCR:  highAddr = addrExt + spanExt - EXT_W'(1);
      BURST_WRAP: begin
        lowAddr  = addrExt & ~(spanExt - EXT_W'(1));
        highAddr = lowAddr + spanExt - EXT_W'(1);
      end
      default: badBurst = 1'b1;
    endcase
  end

  assign overflow = highAddr[ADDR_W];

  for (genvar i = 0; i < NREG; i++) begin : g_region
    logic [ADDR_W-1:0] lo, hi;
    assign lo       = regionLo[i*ADDR_W +: ADDR_W];
    assign hi       = regionHi[i*ADDR_W +: ADDR_W];
    assign hitLo[i] = regionEn[i] && (lowAddr[ADDR_W-1:0] >= lo) && (lowAddr[ADDR_W-1:0] <= hi);
    assign hitHi[i] = regionEn[i] && (highAddr[ADDR_W-1:0] >= lo) && (highAddr[ADDR_W-1:0] <= hi);
  end

  // Scan from the top index down so the lowest matching index decides last
  always_comb begin
    lowAcc  = ACC_NONE;
    highAcc = ACC_NONE;
    for (int i = NREG - 1; i >= 0; i--) begin
      if (hitLo[i]) lowAcc  = decodeAp(regionAp[i*3 +: 3], priv);
      if (hitHi[i]) highAcc = decodeAp(regionAp[i*3 +: 3], priv);
    end
  end

  assign grant = (badBurst || overflow) ? ACC_NONE : tighter(lowAcc, highAcc);

endmodule

// File: rtl/axgate_datapath.sv
module axgate_datapath
  import axgate_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int ID_W   = 4,
  parameter int NREG   = 4,
  parameter int CTRL_W = ID_W + 16
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [NREG-1:0]        regionEn,
  input  logic [NREG*ADDR_W-1:0] regionLo,
  input  logic [NREG*ADDR_W-1:0] regionHi,
  input  logic [NREG*3-1:0]      regionAp,
  input  logic [ADDR_W-1:0]      awAddr,
  input  logic [ID_W-1:0]        awId,
  input  logic [7:0]             awLen,
  input  logic [2:0]             awSize,
  input  logic [1:0]             awBurst,
  input  logic [2:0]             awProt,
  input  logic [ADDR_W-1:0]      arAddr,
  input  logic [ID_W-1:0]        arId,
  input  logic [7:0]             arLen,
  input  logic [2:0]             arSize,
  input  logic [1:0]             arBurst,
  input  logic [2:0]             arProt,
  input  strobe_t                strobe,
  output logic                   awOk,
  output logic                   arOk,
  output logic [ADDR_W-1:0]      werrAddr,
  output logic [CTRL_W-1:0]      werrCtrl,
  output logic [ADDR_W-1:0]      rerrAddr,
  output logic [CTRL_W-1:0]      rerrCtrl
);
  access_e awGrant, arGrant;

  axgate_perm #(.ADDR_W(ADDR_W), .NREG(NREG)) u_awPerm (
    .addr(awAddr), .len(awLen), .size(awSize), .burst(awBurst), .priv(awProt[0]),
    .regionEn(regionEn), .regionLo(regionLo), .regionHi(regionHi), .regionAp(regionAp),
    .grant(awGrant)
  );

  axgate_perm #(.ADDR_W(ADDR_W), .NREG(NREG)) u_arPerm (
    .addr(arAddr), .len(arLen), .size(arSize), .burst(arBurst), .priv(arProt[0]),
    .regionEn(regionEn), .regionLo(regionLo), .regionHi(regionHi), .regionAp(regionAp),
    .grant(arGrant)
  );

  assign awOk = (awGrant == ACC_RW);
  assign arOk = (arGrant != ACC_NONE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      werrAddr <= '0;
      werrCtrl <= '0;
      rerrAddr <= '0;
      rerrCtrl <= '0;
    end else begin
      if (strobe.loadW) begin
        werrAddr <= awAddr;
        werrCtrl <= {awId, awLen, awSize, awBurst, awProt};
      end
      if (strobe.loadR) begin
        rerrAddr <= arAddr;
        rerrCtrl <= {arId, arLen, arSize, arBurst, arProt};
      end
    end
  end

  // R8: a write capture only happens when the write side was not granted
  p_capture_on_deny_r8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadW |-> !awOk);

endmodule

// File: rtl/axgate_ctrl.sv
module axgate_ctrl
  import axgate_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    mAwvalid,
  input  logic    mArvalid,
  input  logic    sAwready,
  input  logic    sArready,
  input  logic    awOk,
  input  logic    arOk,
  input  logic    errClear,
  output logic    sAwvalid,
  output logic    sArvalid,
  output logic    mAwready,
  output logic    mArready,
  output logic    irqFlag,
  output strobe_t strobe
);
  logic flagQ, live, awViol, arViol;

  assign live   = !flagQ;
  assign awViol = live && mAwvalid && !awOk;
  assign arViol = live && mArvalid && !arOk;

  assign strobe.loadW   = awViol;
  assign strobe.loadR   = arViol;
  assign strobe.setFlag = awViol || arViol;

  assign sAwvalid = live && awOk && mAwvalid;
  assign mAwready = live && awOk && sAwready;
  assign sArvalid = live && arOk && mArvalid;
  assign mArready = live && arOk && sArready;
  assign irqFlag  = flagQ;

  always_ff @(posedge clk) begin
    if (!rstN)                flagQ <= 1'b0;
    else if (strobe.setFlag)  flagQ <= 1'b1;
    else if (errClear)        flagQ <= 1'b0;
  end

  // R7: a denied request with the gate open raises the flag
  p_deny_sets_flag_r7: assert property (@(posedge clk) disable iff (!rstN)
    (mAwvalid && !awOk && !irqFlag) |=> irqFlag);
  // R10: the flag holds without a clear
  p_flag_sticky_r10: assert property (@(posedge clk) disable iff (!rstN)
    (irqFlag && !errClear) |=> irqFlag);
  // R11: a clear while flagged drops the flag
  p_clear_drops_r11: assert property (@(posedge clk) disable iff (!rstN)
    (irqFlag && errClear) |=> !irqFlag);
  // R1: no write acceptance toward the master without memory readiness
  p_aw_ready_r1: assert property (@(posedge clk) disable iff (!rstN)
    mAwready |-> sAwready);

endmodule

// File: rtl/axi_addr_guard.sv
module axi_addr_guard
  import axgate_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int ID_W   = 4,
  parameter int NREG   = 4,
  localparam int CTRL_W = ID_W + 16
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [NREG-1:0]        regionEn,
  input  logic [NREG*ADDR_W-1:0] regionLo,
  input  logic [NREG*ADDR_W-1:0] regionHi,
  input  logic [NREG*3-1:0]      regionAp,
  input  logic                   mAwvalid,
  output logic                   mAwready,
  input  logic [ADDR_W-1:0]      mAwaddr,
  input  logic [ID_W-1:0]        mAwid,
  input  logic [7:0]             mAwlen,
  input  logic [2:0]             mAwsize,
  input  logic [1:0]             mAwburst,
  input  logic [2:0]             mAwprot,
  output logic                   sAwvalid,
  input  logic                   sAwready,
  output logic [ADDR_W-1:0]      sAwaddr,
  output logic [ID_W-1:0]        sAwid,
  output logic [7:0]             sAwlen,
  output logic [2:0]             sAwsize,
  output logic [1:0]             sAwburst,
  output logic [2:0]             sAwprot,
  input  logic                   mArvalid,
  output logic                   mArready,
  input  logic [ADDR_W-1:0]      mAraddr,
  input  logic [ID_W-1:0]        mArid,
  input  logic [7:0]             mArlen,
  input  logic [2:0]             mArsize,
  input  logic [1:0]             mArburst,
  input  logic [2:0]             mArprot,
  output logic                   sArvalid,
  input  logic                   sArready,
  output logic [ADDR_W-1:0]      sAraddr,
  output logic [ID_W-1:0]        sArid,
  output logic [7:0]             sArlen,
  output logic [2:0]             sArsize,
  output logic [1:0]             sArburst,
  output logic [2:0]             sArprot,
  input  logic                   errClear,
  output logic                   irqFlag,
  output logic [ADDR_W-1:0]      werrAddr,
  output logic [CTRL_W-1:0]      werrCtrl,
  output logic [ADDR_W-1:0]      rerrAddr,
  output logic [CTRL_W-1:0]      rerrCtrl
);
  logic    awOk, arOk;
  strobe_t strobe;

  assign sAwaddr  = mAwaddr;
  assign sAwid    = mAwid;
  assign sAwlen   = mAwlen;
  assign sAwsize  = mAwsize;
  assign sAwburst = mAwburst;
  assign sAwprot  = mAwprot;
  assign sAraddr  = mAraddr;
  assign sArid    = mArid;
  assign sArlen   = mArlen;
  assign sArsize  = mArsize;
  assign sArburst = mArburst;
  assign sArprot  = mArprot;

  axgate_datapath #(.ADDR_W(ADDR_W), .ID_W(ID_W), .NREG(NREG), .CTRL_W(CTRL_W)) u_dp (
    .clk(clk), .rstN(rstN),
    .regionEn(regionEn), .regionLo(regionLo), .regionHi(regionHi), .regionAp(regionAp),
    .awAddr(mAwaddr), .awId(mAwid), .awLen(mAwlen), .awSize(mAwsize),
    .awBurst(mAwburst), .awProt(mAwprot),
    .arAddr(mAraddr), .arId(mArid), .arLen(mArlen), .arSize(mArsize),
    .arBurst(mArburst), .arProt(mArprot),
    .strobe(strobe), .awOk(awOk), .arOk(arOk),
    .werrAddr(werrAddr), .werrCtrl(werrCtrl), .rerrAddr(rerrAddr), .rerrCtrl(rerrCtrl)
  );

  axgate_ctrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .mAwvalid(mAwvalid), .mArvalid(mArvalid), .sAwready(sAwready), .sArready(sArready),
    .awOk(awOk), .arOk(arOk), .errClear(errClear),
    .sAwvalid(sAwvalid), .sArvalid(sArvalid), .mAwready(mAwready), .mArready(mArready),
    .irqFlag(irqFlag), .strobe(strobe)
  );

  // R10: frozen interface while flagged
  p_frozen_r10: assert property (@(posedge clk) disable iff (!rstN)
    irqFlag |-> (!sAwvalid && !sArvalid && !mAwready && !mArready));
  // R10: no capture while flagged
  p_err_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    irqFlag |=> ($stable(werrAddr) && $stable(rerrAddr) && $stable(werrCtrl) && $stable(rerrCtrl)));
  // R2: memory-side read valid only follows a master request
  p_ar_valid_r2: assert property (@(posedge clk) disable iff (!rstN)
    sArvalid |-> mArvalid);

endmodule

// File: tb/axi_addr_guard_test.sv
module axi_addr_guard_test;
  localparam int ADDR_W = 32;
  localparam int ID_W   = 4;
  localparam int NREG   = 4;
  localparam int CTRL_W = ID_W + 16;
  localparam int VEC_W  = 50;
  localparam int NV     = 20;

  // {isWrite, addr, len, size, burst, prot, expectAllow}
  localparam logic [VEC_W-1:0] VECS [NV] = '{
    {1'b1, 32'h0000_1000, 8'd0,  3'd2, 2'b01, 3'b001, 1'b1}, // R1 R4 region 0 rw
    {1'b1, 32'h0000_1800, 8'd0,  3'd2, 2'b01, 3'b001, 1'b1}, // R3 overlap, index 0 wins
    {1'b1, 32'h0000_2000, 8'd0,  3'd2, 2'b01, 3'b001, 1'b0}, // R4 code 101 priv ro, write denied
    {1'b0, 32'h0000_2000, 8'd0,  3'd2, 2'b01, 3'b001, 1'b1}, // R2 R4 read ok
    {1'b0, 32'h0000_2000, 8'd0,  3'd2, 2'b01, 3'b000, 1'b0}, // R5 code 101 user none
    {1'b1, 32'h0000_3000, 8'd0,  3'd2, 2'b01, 3'b000, 1'b0}, // R5 code 010 user ro
    {1'b0, 32'h0000_3000, 8'd0,  3'd2, 2'b01, 3'b000, 1'b1}, // R5 read ok
    {1'b1, 32'h0000_3000, 8'd0,  3'd2, 2'b01, 3'b001, 1'b1}, // R4 code 010 priv rw
    {1'b0, 32'h0000_5000, 8'd0,  3'd2, 2'b01, 3'b001, 1'b0}, // R3 no region
    {1'b1, 32'h0000_1FF0, 8'd3,  3'd2, 2'b01, 3'b001, 1'b1}, // R6 ends at 1FFF
    {1'b1, 32'h0000_1FF0, 8'd4,  3'd2, 2'b01, 3'b001, 1'b0}, // R6 end in ro region
    {1'b0, 32'h0000_1FF0, 8'd4,  3'd2, 2'b01, 3'b001, 1'b1}, // R6 read tighter = ro
    {1'b1, 32'h0000_1FFC, 8'd3,  3'd2, 2'b10, 3'b001, 1'b1}, // R6 wrap stays in 1FF0-1FFF
    {1'b1, 32'h0000_1FFC, 8'd3,  3'd2, 2'b01, 3'b001, 1'b0}, // R6 incr crosses to 200B
    {1'b1, 32'h0000_1FFC, 8'd15, 3'd2, 2'b00, 3'b001, 1'b1}, // R6 fixed one beat
    {1'b1, 32'h0000_1000, 8'd0,  3'd2, 2'b11, 3'b001, 1'b0}, // R6 reserved burst
    {1'b0, 32'hFFFF_FFF0, 8'd3,  3'd2, 2'b01, 3'b001, 1'b1}, // R6 ends exactly at top
    {1'b0, 32'hFFFF_FFF0, 8'd4,  3'd2, 2'b01, 3'b001, 1'b0}, // R6 wraps past top
    {1'b1, 32'h0000_1000, 8'd0,  3'd2, 2'b01, 3'b000, 1'b1}, // R5 code 111 user rw
    {1'b1, 32'h0000_0800, 8'd0,  3'd2, 2'b01, 3'b001, 1'b0}  // R3 below all regions
  };

  logic clk = 1'b0;
  logic rstN;
  logic [NREG-1:0]        regionEn;
  logic [NREG*ADDR_W-1:0] regionLo, regionHi;
  logic [NREG*3-1:0]      regionAp;
  logic mAwvalid, mAwready, sAwvalid, sAwready;
  logic [ADDR_W-1:0] mAwaddr, sAwaddr;
  logic [ID_W-1:0] mAwid, sAwid;
  logic [7:0] mAwlen, sAwlen;
  logic [2:0] mAwsize, sAwsize, mAwprot, sAwprot;
  logic [1:0] mAwburst, sAwburst;
  logic mArvalid, mArready, sArvalid, sArready;
  logic [ADDR_W-1:0] mAraddr, sAraddr;
  logic [ID_W-1:0] mArid, sArid;
  logic [7:0] mArlen, sArlen;
  logic [2:0] mArsize, sArsize, mArprot, sArprot;
  logic [1:0] mArburst, sArburst;
  logic errClear, irqFlag;
  logic [ADDR_W-1:0] werrAddr, rerrAddr;
  logic [CTRL_W-1:0] werrCtrl, rerrCtrl;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  axi_addr_guard #(.ADDR_W(ADDR_W), .ID_W(ID_W), .NREG(NREG)) uut (.*);

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic setAw(input logic v, input logic [31:0] a, input logic [3:0] id, input logic [7:0] l,
                       input logic [2:0] s, input logic [1:0] b, input logic [2:0] p);
    mAwvalid = v; mAwaddr = a; mAwid = id; mAwlen = l; mAwsize = s; mAwburst = b; mAwprot = p;
  endtask

  task automatic setAr(input logic v, input logic [31:0] a, input logic [3:0] id, input logic [7:0] l,
                       input logic [2:0] s, input logic [1:0] b, input logic [2:0] p);
    mArvalid = v; mAraddr = a; mArid = id; mArlen = l; mArsize = s; mArburst = b; mArprot = p;
  endtask

  task automatic runVec(input int idx, input logic [VEC_W-1:0] vec);
    logic isW, ex;
    isW = vec[49];
    ex  = vec[0];
    @(negedge clk);
    if (isW) setAw(1'b1, vec[48:17], 4'd7, vec[16:9], vec[8:6], vec[5:4], vec[3:1]);
    else     setAr(1'b1, vec[48:17], 4'd7, vec[16:9], vec[8:6], vec[5:4], vec[3:1]);
    #2;
    if (isW) begin
      chk(sAwvalid == ex, $sformatf("R1 R3 R4 R5 R6 vec%0d sAwvalid", idx), 64'(sAwvalid), 64'(ex));
      chk(mAwready == ex, $sformatf("R1 R7 vec%0d mAwready", idx), 64'(mAwready), 64'(ex));
      if (ex) chk({sAwaddr, sAwlen, sAwburst} == {vec[48:17], vec[16:9], vec[5:4]},
                  $sformatf("R1 vec%0d payload", idx), 64'(sAwaddr), 64'(vec[48:17]));
    end else begin
      chk(sArvalid == ex, $sformatf("R2 R3 R4 R5 R6 vec%0d sArvalid", idx), 64'(sArvalid), 64'(ex));
      chk(mArready == ex, $sformatf("R2 R7 vec%0d mArready", idx), 64'(mArready), 64'(ex));
      if (ex) chk({sAraddr, sArlen, sArburst} == {vec[48:17], vec[16:9], vec[5:4]},
                  $sformatf("R2 vec%0d payload", idx), 64'(sAraddr), 64'(vec[48:17]));
    end
    @(negedge clk);
    mAwvalid = 1'b0; mArvalid = 1'b0;
    #1 chk(irqFlag == !ex, $sformatf("R7 vec%0d flag", idx), 64'(irqFlag), 64'(!ex));
    if (!ex) begin
      errClear = 1'b1;
      @(negedge clk);
      errClear = 1'b0;
      #1 chk(irqFlag == 1'b0, $sformatf("R11 vec%0d cleared", idx), 64'(irqFlag), 64'd0);
    end
  endtask

  task automatic clearFlag();
    @(negedge clk);
    errClear = 1'b1;
    @(negedge clk);
    errClear = 1'b0;
  endtask

  initial begin
    #2_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rstN = 1'b0;
    errClear = 1'b0;
    sAwready = 1'b1;
    sArready = 1'b1;
    setAw(1'b0, '0, '0, '0, '0, '0, '0);
    setAr(1'b0, '0, '0, '0, '0, '0, '0);
    regionEn = 4'b1111;
    regionLo = {32'hFFFF_0000, 32'h0000_3000, 32'h0000_1800, 32'h0000_1000};
    regionHi = {32'hFFFF_FFFF, 32'h0000_3FFF, 32'h0000_2FFF, 32'h0000_1FFF};
    regionAp = {3'b111, 3'b010, 3'b101, 3'b111};
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    // R12 reset state
    chk(irqFlag == 1'b0, "R12 flag", 64'(irqFlag), 64'd0);
    chk(werrAddr == '0 && werrCtrl == '0, "R12 write error regs", 64'(werrAddr), 64'd0);
    chk(rerrAddr == '0 && rerrCtrl == '0, "R12 read error regs", 64'(rerrAddr), 64'd0);
    chk(sAwvalid == 1'b0 && sArvalid == 1'b0, "R12 idle valids", 64'({sAwvalid, sArvalid}), 64'd0);

    for (int v = 0; v < NV; v++) runVec(v, VECS[v]);

    // R8 R9: both channels violate in one cycle
    @(negedge clk);
    setAw(1'b1, 32'h0000_0800, 4'd5, 8'd3, 3'd2, 2'b01, 3'b011);
    setAr(1'b1, 32'h0000_4000, 4'd9, 8'd0, 3'd1, 2'b00, 3'b001);
    @(negedge clk);
    #1;
    chk(irqFlag == 1'b1, "R7 flag after double violation", 64'(irqFlag), 64'd1);
    chk(werrAddr == 32'h0000_0800, "R8 werrAddr", 64'(werrAddr), 64'h800);
    chk(werrCtrl == {4'd5, 8'd3, 3'd2, 2'b01, 3'b011}, "R8 werrCtrl", 64'(werrCtrl),
        64'({4'd5, 8'd3, 3'd2, 2'b01, 3'b011}));
    chk(rerrAddr == 32'h0000_4000, "R9 rerrAddr", 64'(rerrAddr), 64'h4000);
    chk(rerrCtrl == {4'd9, 8'd0, 3'd1, 2'b00, 3'b001}, "R9 rerrCtrl", 64'(rerrCtrl),
        64'({4'd9, 8'd0, 3'd1, 2'b00, 3'b001}));

    // R10: frozen while flagged, permitted write and violating read both ignored
    setAw(1'b1, 32'h0000_1000, 4'd1, 8'd0, 3'd2, 2'b01, 3'b001);
    setAr(1'b1, 32'h0000_0900, 4'd2, 8'd0, 3'd2, 2'b01, 3'b001);
    #1;
    chk({sAwvalid, mAwready, sArvalid, mArready} == 4'b0000, "R10 frozen outputs",
        64'({sAwvalid, mAwready, sArvalid, mArready}), 64'd0);
    repeat (3) @(negedge clk);
    #1;
    chk(irqFlag == 1'b1, "R10 flag sticky", 64'(irqFlag), 64'd1);
    chk(rerrAddr == 32'h0000_4000, "R10 rerrAddr unchanged", 64'(rerrAddr), 64'h4000);
    chk(werrAddr == 32'h0000_0800, "R10 werrAddr unchanged", 64'(werrAddr), 64'h800);
    chk(sAwvalid == 1'b0, "R10 write still blocked", 64'(sAwvalid), 64'd0);

    // R11: clear releases the gate one edge later
    errClear = 1'b1;
    #1 chk(sAwvalid == 1'b0, "R11 blocked during clear cycle", 64'(sAwvalid), 64'd0);
    @(negedge clk);
    errClear = 1'b0;
    #1;
    chk(irqFlag == 1'b0, "R11 flag dropped", 64'(irqFlag), 64'd0);
    chk(sAwvalid == 1'b1 && mAwready == 1'b1, "R11 write resumes", 64'({sAwvalid, mAwready}), 64'h3);
    chk(sArvalid == 1'b0, "R11 R7 read still denied", 64'(sArvalid), 64'd0);
    @(negedge clk);
    #1;
    chk(irqFlag == 1'b1, "R7 re-flagged", 64'(irqFlag), 64'd1);
    chk(rerrAddr == 32'h0000_0900, "R9 new read capture", 64'(rerrAddr), 64'h900);
    chk(werrAddr == 32'h0000_0800, "R8 write regs kept", 64'(werrAddr), 64'h800);
    mAwvalid = 1'b0; mArvalid = 1'b0;
    clearFlag();
    #1 chk(irqFlag == 1'b0, "R11 cleared again", 64'(irqFlag), 64'd0);

    // R11: clear coinciding with a violation leaves the flag set
    @(negedge clk);
    errClear = 1'b1;
    setAr(1'b1, 32'h0000_0A00, 4'd3, 8'd0, 3'd2, 2'b01, 3'b001);
    @(negedge clk);
    errClear = 1'b0;
    mArvalid = 1'b0;
    #1;
    chk(irqFlag == 1'b1, "R11 violation beats clear", 64'(irqFlag), 64'd1);
    chk(rerrAddr == 32'h0000_0A00, "R9 capture with clear", 64'(rerrAddr), 64'hA00);
    clearFlag();

    // R3: disabled region grants nothing
    @(negedge clk);
    regionEn = 4'b0111;
    setAr(1'b1, 32'hFFFF_0000, 4'd0, 8'd0, 3'd2, 2'b01, 3'b001);
    #2 chk(sArvalid == 1'b0, "R3 disabled region", 64'(sArvalid), 64'd0);
    @(negedge clk);
    mArvalid = 1'b0;
    regionEn = 4'b1111;
    clearFlag();
    #1 chk(irqFlag == 1'b0, "R11 final clear", 64'(irqFlag), 64'd0);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule